// File: doc/BRIEF.md
# Global 64-bit Timer with Self-Rearming Comparator

This block is a shared timebase for a chip. A 64-bit counter advances by one on every clock while it is running. Software reads and writes the counter as two 32-bit halves. A single 64-bit comparator watches the counter and latches an interrupt when the two values are equal. When auto-increment is on, the comparator adds a 32-bit step to its own compare value on every hit, so events repeat at a fixed period without software action.

Writes to the counter, the control word, the compare halves and the step do not take effect at once. They travel through a short internal delay line, which models a slower timer clock domain. When a write lands, it sets a sticky completion flag. Software polls that flag and then clears it by writing 1. Writes to the interrupt enable, the interrupt status and the two completion-flag registers act on the next clock edge.

Top module: `tmr64_global`

## Requirements
- R1: After reset, every readable register reads zero, `irq` is low and the counter is stopped.
- R2: While the start bit (control bit 8) is set, the counter grows by exactly one per clock. While it is clear, the counter holds its value.
- R3: Register index 0 holds counter bits 31:0 and index 1 holds bits 63:32. A carry out of the low half reaches the high half. All-ones is followed by zero.
- R4: A write to index 0, 1, 3, 4, 5 or 6 changes the register exactly two clock edges after the edge that samples the bus write. A read in between returns the old value.
- R5: When a delayed write lands, it sets its completion flag. The comparator flag register (index 7) uses bit 0 for compare-low (index 4), bit 1 for compare-high (index 5), bit 2 for step (index 6) and bit 16 for control (index 3). The counter flag register (index 2) uses bit 0 for the low half and bit 1 for the high half.
- R6: Writing 1 to a bit of index 2 or 7 clears that flag. Writing 0 leaves it unchanged. If a clear and a landing write meet on the same edge, the flag stays set.
- R7: A match is exact 64-bit equality between the counter and the compare value (low word at index 4, high word at index 5), taken while the counter runs and the compare-enable bit (control bit 0) is set. A match sets interrupt status bit 0 (index 9). With compare-enable clear, nothing is latched, even if auto-increment is set.
- R8: If auto-increment (control bit 1) is set, each match adds the step register (index 6), zero-extended, to the compare value. Matches then repeat every step cycles.
- R9: If auto-increment is clear, the compare value is left unchanged and a programmed value fires once, until the counter wraps.
- R10: `irq` is a register that equals (interrupt enable bit 0, index 8) AND (status bit 0) as they stood one clock earlier.
- R11: Writing 1 to bit 0 of index 9 clears the status, unless a match occurs on the same edge.
- R12: `bus_rdata` is registered. It shows the addressed register as it stood at the edge that samples `bus_rd`. Unused indices read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
A counter that has slipped by even one count shows up on the next read of either half. An early or late delayed write is exposed by a read placed on the cycle after the write, before the expected landing. A compare value that was reloaded wrongly, or an enable that was not applied, moves or removes the next interrupt. Because `irq` is compared on every clock, such a fault is reported within one cycle of the expected event. Completion flags that are lost or that clear wrongly are caught by status reads placed right after each landing and each clear.

// File: rtl/tmr64_pkg.sv
`timescale 1ns/1ps
package tmr64_pkg;
  localparam int IDX_W = 4;

  typedef enum logic [IDX_W-1:0] {
    REG_CNT_LO  = 4'd0,
    REG_CNT_HI  = 4'd1,
    REG_CNT_WST = 4'd2,
    REG_CTRL    = 4'd3,
    REG_CMP_LO  = 4'd4,
    REG_CMP_HI  = 4'd5,
    REG_STEP    = 4'd6,
    REG_CMP_WST = 4'd7,
    REG_IRQ_EN  = 4'd8,
    REG_IRQ_ST  = 4'd9
  } reg_idx_e;

  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_AINC_BIT  = 1;
  localparam int CTRL_START_BIT = 8;

  localparam int WST_CMP_LO = 0;
  localparam int WST_CMP_HI = 1;
  localparam int WST_STEP   = 2;
  localparam int WST_CTRL   = 16;
  localparam int CWST_LO    = 0;
  localparam int CWST_HI    = 1;

  function automatic logic is_delayed(input logic [IDX_W-1:0] idx);
    return (idx == REG_CNT_LO) || (idx == REG_CNT_HI) || (idx == REG_CTRL) ||
           (idx == REG_CMP_LO) || (idx == REG_CMP_HI) || (idx == REG_STEP);
  endfunction
endpackage

// File: rtl/tmr64_wrpipe.sv
`timescale 1ns/1ps
module tmr64_wrpipe #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int LAT    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_vld,
  input  logic [IDX_W-1:0]  in_idx,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  output logic [IDX_W-1:0]  out_idx,
  output logic [DATA_W-1:0] out_data
);
  logic [LAT-1:0]    vld_q;
  logic [IDX_W-1:0]  idx_q [LAT];
  logic [DATA_W-1:0] dat_q [LAT];

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else begin
      vld_q[0] <= in_vld;
      for (int s = 1; s < LAT; s++) vld_q[s] <= vld_q[s-1];
    end
  end

  always_ff @(posedge clk) begin
    idx_q[0] <= in_idx;
    dat_q[0] <= in_data;
    for (int s = 1; s < LAT; s++) begin
      idx_q[s] <= idx_q[s-1];
      dat_q[s] <= dat_q[s-1];
    end
  end

  assign out_vld  = vld_q[LAT-1];
  assign out_idx  = idx_q[LAT-1];
  assign out_data = dat_q[LAT-1];
endmodule

// File: rtl/tmr64_counter.sv
`timescale 1ns/1ps
module tmr64_counter #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic [DATA_W-1:0]   ld_data,
  output logic [2*DATA_W-1:0] cnt
);
  localparam int CW = 2 * DATA_W;
  logic [CW-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = run ? cnt + CW'(1) : cnt;
    if (ld_lo) cnt_nxt[DATA_W-1:0]  = ld_data;
    if (ld_hi) cnt_nxt[CW-1:DATA_W] = ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt_nxt;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !ld_lo && !ld_hi) |=> (cnt == $past(cnt) + CW'(1)));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !ld_lo && !ld_hi) |=> $stable(cnt));
  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !ld_lo && !ld_hi && (&cnt)) |=> (cnt == '0));
endmodule

// File: rtl/tmr64_cmp.sv
`timescale 1ns/1ps
module tmr64_cmp #(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2*DATA_W-1:0] cnt,
  input  logic                run,
  input  logic                cmp_en,
  input  logic                auto_inc,
  input  logic                ld_lo,
  input  logic                ld_hi,
  input  logic                ld_step,
  input  logic [DATA_W-1:0]   ld_data,
  output logic                match,
  output logic [2*DATA_W-1:0] cmp,
  output logic [DATA_W-1:0]   step
);
  localparam int CW = 2 * DATA_W;
  logic [CW-1:0] cmp_nxt;

  assign match = run && cmp_en && (cnt == cmp);

  always_comb begin
    cmp_nxt = (match && auto_inc) ? cmp + CW'(step) : cmp;
    if (ld_lo) cmp_nxt[DATA_W-1:0]  = ld_data;
    if (ld_hi) cmp_nxt[CW-1:DATA_W] = ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp  <= '0;
      step <= '0;
    end else begin
      cmp <= cmp_nxt;
      if (ld_step) step <= ld_data;
    end
  end

  // R8
  cmp_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (match && auto_inc && !ld_lo && !ld_hi) |=> (cmp == $past(cmp) + CW'($past(step))));
  // R9
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!(match && auto_inc) && !ld_lo && !ld_hi) |=> $stable(cmp));
endmodule

// File: rtl/tmr64_global.sv
`timescale 1ns/1ps
module tmr64_global
  import tmr64_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WR_LAT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [IDX_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CW = 2 * DATA_W;

  logic              ap_vld;
  logic [IDX_W-1:0]  ap_idx;
  logic [DATA_W-1:0] ap_data;
  logic [CW-1:0]     cnt, cmp;
  logic [DATA_W-1:0] step;
  logic              match;

  logic              start_q, en_q, ainc_q, ie_q, istat_q;
  logic [DATA_W-1:0] wst_q, cwst_q;
  logic [DATA_W-1:0] wst_set, wst_clr, cwst_set, cwst_clr, rd_mux;
  logic              ap_cnt_lo, ap_cnt_hi, ap_ctrl, ap_cmp_lo, ap_cmp_hi, ap_step;
  logic              wr_ie, wr_ist;

  tmr64_wrpipe #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LAT(WR_LAT)) u_pipe (
    .clk(clk), .rst(rst),
    .in_vld(bus_wr && is_delayed(bus_addr)), .in_idx(bus_addr), .in_data(bus_wdata),
    .out_vld(ap_vld), .out_idx(ap_idx), .out_data(ap_data)
  );

  assign ap_cnt_lo = ap_vld && (ap_idx == REG_CNT_LO);
  assign ap_cnt_hi = ap_vld && (ap_idx == REG_CNT_HI);
  assign ap_ctrl   = ap_vld && (ap_idx == REG_CTRL);
  assign ap_cmp_lo = ap_vld && (ap_idx == REG_CMP_LO);
  assign ap_cmp_hi = ap_vld && (ap_idx == REG_CMP_HI);
  assign ap_step   = ap_vld && (ap_idx == REG_STEP);
  assign wr_ie     = bus_wr && (bus_addr == REG_IRQ_EN);
  assign wr_ist    = bus_wr && (bus_addr == REG_IRQ_ST);

  tmr64_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .run(start_q),
    .ld_lo(ap_cnt_lo), .ld_hi(ap_cnt_hi), .ld_data(ap_data), .cnt(cnt)
  );

  tmr64_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .cnt(cnt), .run(start_q), .cmp_en(en_q), .auto_inc(ainc_q),
    .ld_lo(ap_cmp_lo), .ld_hi(ap_cmp_hi), .ld_step(ap_step), .ld_data(ap_data),
    .match(match), .cmp(cmp), .step(step)
  );

  always_comb begin
    wst_set = '0;
    wst_set[WST_CMP_LO] = ap_cmp_lo;
    wst_set[WST_CMP_HI] = ap_cmp_hi;
    wst_set[WST_STEP]   = ap_step;
    wst_set[WST_CTRL]   = ap_ctrl;
    cwst_set = '0;
    cwst_set[CWST_LO] = ap_cnt_lo;
    cwst_set[CWST_HI] = ap_cnt_hi;
    wst_clr  = (bus_wr && (bus_addr == REG_CMP_WST)) ? bus_wdata : '0;
    cwst_clr = (bus_wr && (bus_addr == REG_CNT_WST)) ? bus_wdata : '0;
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      REG_CNT_LO:  rd_mux = cnt[DATA_W-1:0];
      REG_CNT_HI:  rd_mux = cnt[CW-1:DATA_W];
      REG_CNT_WST: rd_mux = cwst_q;
      REG_CTRL: begin
        rd_mux[CTRL_EN_BIT]    = en_q;
        rd_mux[CTRL_AINC_BIT]  = ainc_q;
        rd_mux[CTRL_START_BIT] = start_q;
      end
      REG_CMP_LO:  rd_mux = cmp[DATA_W-1:0];
      REG_CMP_HI:  rd_mux = cmp[CW-1:DATA_W];
      REG_STEP:    rd_mux = step;
      REG_CMP_WST: rd_mux = wst_q;
      REG_IRQ_EN:  rd_mux[0] = ie_q;
      REG_IRQ_ST:  rd_mux[0] = istat_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0; en_q <= 1'b0; ainc_q <= 1'b0;
      ie_q <= 1'b0; istat_q <= 1'b0; irq <= 1'b0;
      wst_q <= '0; cwst_q <= '0; bus_rdata <= '0;
    end else begin
      if (ap_ctrl) begin
        start_q <= ap_data[CTRL_START_BIT];
        en_q    <= ap_data[CTRL_EN_BIT];
        ainc_q  <= ap_data[CTRL_AINC_BIT];
      end
      if (wr_ie) ie_q <= bus_wdata[0];
      istat_q <= (istat_q && !(wr_ist && bus_wdata[0])) || match;
      wst_q   <= (wst_q & ~wst_clr) | wst_set;
      cwst_q  <= (cwst_q & ~cwst_clr) | cwst_set;
      irq     <= ie_q && istat_q;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  // R7
  istat_set_chk: assert property (@(posedge clk) disable iff (rst)
    match |=> istat_q);
  // R10
  irq_on_chk: assert property (@(posedge clk) disable iff (rst)
    (ie_q && istat_q) |=> irq);
  // R10
  irq_off_chk: assert property (@(posedge clk) disable iff (rst)
    !(ie_q && istat_q) |=> !irq);
  // R6
  wst_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == REG_CMP_WST) && bus_wdata[WST_CMP_LO] && !ap_cmp_lo)
    |=> !wst_q[WST_CMP_LO]);
  // R4
  ctrl_late_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && (bus_addr == REG_CTRL) && !ap_ctrl) |=> $stable({start_q, en_q, ainc_q}));
endmodule

// File: tb/tmr64_global_bench.sv
`timescale 1ns/1ps
module tmr64_global_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0, errors = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  tmr64_global u_tmr64_global (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference model state
  logic [63:0] m_cnt, m_cmp;
  logic [31:0] m_step, m_wst, m_cwst, m_rdata;
  logic        m_start, m_en, m_ainc, m_ie, m_istat, m_irq, m_rvalid;
  int          q_cd[$];
  logic [3:0]  q_idx[$];
  logic [31:0] q_dat[$];

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_cnt[31:0];
      4'd1: return m_cnt[63:32];
      4'd2: return m_cwst;
      4'd3: return {23'd0, m_start, 6'd0, m_ainc, m_en};
      4'd4: return m_cmp[31:0];
      4'd5: return m_cmp[63:32];
      4'd6: return m_step;
      4'd7: return m_wst;
      4'd8: return {31'd0, m_ie};
      4'd9: return {31'd0, m_istat};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_cmp = 0; m_step = 0; m_wst = 0; m_cwst = 0; m_rdata = 0;
      m_start = 0; m_en = 0; m_ainc = 0; m_ie = 0; m_istat = 0; m_irq = 0; m_rvalid = 0;
      q_cd.delete(); q_idx.delete(); q_dat.delete();
    end else begin
      logic        hit, n_start, n_en, n_ainc;
      logic [63:0] n_cnt, n_cmp;
      logic [31:0] n_step, s_w, s_c;
      hit = m_start && m_en && (m_cnt == m_cmp);
      m_rvalid = bus_rd;
      if (bus_rd) m_rdata = m_read(bus_addr);
      n_cnt = m_start ? m_cnt + 64'd1 : m_cnt;
      n_cmp = (hit && m_ainc) ? m_cmp + {32'd0, m_step} : m_cmp;
      n_step = m_step; n_start = m_start; n_en = m_en; n_ainc = m_ainc;
      s_w = 0; s_c = 0;
      foreach (q_cd[i]) q_cd[i]--;
      while (q_cd.size() > 0 && q_cd[0] == 0) begin
        logic [31:0] d;
        d = q_dat[0];
        case (q_idx[0])
          4'd0: begin n_cnt[31:0] = d; s_c[0] = 1; end
          4'd1: begin n_cnt[63:32] = d; s_c[1] = 1; end
          4'd3: begin n_start = d[8]; n_en = d[0]; n_ainc = d[1]; s_w[16] = 1; end
          4'd4: begin n_cmp[31:0] = d; s_w[0] = 1; end
          4'd5: begin n_cmp[63:32] = d; s_w[1] = 1; end
          4'd6: begin n_step = d; s_w[2] = 1; end
          default: ;
        endcase
        void'(q_cd.pop_front()); void'(q_idx.pop_front()); void'(q_dat.pop_front());
      end
      m_irq = m_ie && m_istat;
      m_istat = (m_istat && !(bus_wr && bus_addr == 4'd9 && bus_wdata[0])) || hit;
      m_wst  = (m_wst  & ~((bus_wr && bus_addr == 4'd7) ? bus_wdata : 32'd0)) | s_w;
      m_cwst = (m_cwst & ~((bus_wr && bus_addr == 4'd2) ? bus_wdata : 32'd0)) | s_c;
      if (bus_wr && bus_addr == 4'd8) m_ie = bus_wdata[0];
      m_cnt = n_cnt; m_cmp = n_cmp; m_step = n_step;
      m_start = n_start; m_en = n_en; m_ainc = n_ainc;
      if (bus_wr && (bus_addr inside {4'd0, 4'd1, 4'd3, 4'd4, 4'd5, 4'd6})) begin
        q_cd.push_back(2); q_idx.push_back(bus_addr); q_dat.push_back(bus_wdata);
      end
    end
  end

  task automatic chk(input string t, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk("R10 irq", {31'd0, irq}, {31'd0, m_irq});
      if (m_rvalid) chk({tag, " rdata"}, bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    // reset state
    tag = "R1";
    for (int a = 0; a < 12; a++) rd(4'(a));
    // landing delay
    tag = "R4";
    wr(4'd0, 32'hFFFF_FFF0);
    rd(4'd0); rd(4'd0); rd(4'd2); rd(4'd0);
    wr(4'd3, 32'h0000_0100);
    rd(4'd3); rd(4'd3); rd(4'd3);
    wr(4'd3, 32'h0);
    idle(3);
    // completion flags and clearing
    tag = "R5";
    wr(4'd1, 32'h0000_0001); wr(4'd4, 32'd50); wr(4'd5, 32'd1); wr(4'd6, 32'd9);
    idle(3);
    rd(4'd2); rd(4'd7); rd(4'd6);
    tag = "R6";
    wr(4'd7, 32'h0); rd(4'd7);
    wr(4'd7, 32'h0001_0001); rd(4'd7);
    wr(4'd2, 32'h1); rd(4'd2);
    wr(4'd4, 32'd60); idle(1); wr(4'd7, 32'h1); rd(4'd7);
    wr(4'd7, 32'hFFFF_FFFF); wr(4'd2, 32'hFFFF_FFFF); rd(4'd7); rd(4'd2);
    // counting and carry into upper half
    tag = "R2";
    wr(4'd3, 32'h100);
    for (int i = 0; i < 12; i++) begin rd(4'd0); rd(4'd1); end
    wr(4'd3, 32'h0); idle(3);
    rd(4'd0); rd(4'd0); rd(4'd1);
    // wrap through all-ones
    tag = "R3";
    wr(4'd0, 32'hFFFF_FFFA); wr(4'd1, 32'hFFFF_FFFF); idle(3);
    wr(4'd3, 32'h100);
    for (int i = 0; i < 8; i++) begin rd(4'd1); rd(4'd0); end
    // one-shot comparator
    tag = "R9";
    wr(4'd3, 32'h0); idle(3);
    wr(4'd0, 32'd0); wr(4'd1, 32'd0); wr(4'd4, 32'd30); wr(4'd5, 32'd0);
    wr(4'd8, 32'd1); idle(3);
    wr(4'd3, 32'h101);
    idle(50); rd(4'd9); rd(4'd4);
    tag = "R11";
    wr(4'd9, 32'h0); rd(4'd9);
    wr(4'd9, 32'h1); rd(4'd9);
    tag = "R9";
    idle(60); rd(4'd9); rd(4'd4);
    // periodic re-arm
    tag = "R8";
    wr(4'd3, 32'h0); idle(3);
    wr(4'd0, 32'd0); wr(4'd4, 32'd12); wr(4'd6, 32'd7); idle(3);
    wr(4'd3, 32'h103);
    for (int i = 0; i < 20; i++) begin rd(4'd4); rd(4'd9); wr(4'd9, 32'h1); idle(1); end
    // enable clear blocks events
    tag = "R7";
    wr(4'd3, 32'h102); idle(3);
    for (int i = 0; i < 10; i++) begin rd(4'd9); rd(4'd4); wr(4'd9, 32'h1); idle(2); end
    wr(4'd3, 32'h101); idle(3);
    rd(4'd0); rd(4'd4);
    // interrupt gating by enable
    tag = "R10";
    wr(4'd8, 32'd0); wr(4'd0, 32'd0); wr(4'd1, 32'd0); wr(4'd4, 32'd10); idle(20);
    rd(4'd9); wr(4'd8, 32'd1); idle(4); wr(4'd9, 32'd1); idle(3);
    tag = "R12";
    for (int a = 0; a < 16; a++) rd(4'(a));
    idle(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule